// File: doc/BRIEF.md
# UART Receiver Mute and Wake-up Filter

This block sits on the receive path of a UART, after the deserializer and before the receive data register or FIFO. For every character the deserializer hands over, it decides whether the character goes on to the rest of the receiver or is dropped. It supports multi-drop buses, where a receiver stays silent until traffic is addressed to it.

There are two wake methods. With idle-line wake, software puts the receiver into mute, and the filter leaves mute when the deserializer reports a full idle frame. With address-mark wake, a character whose top data bit is set is an address. It is compared against the programmed node address. A mismatch silences the receiver, and a match wakes it. The compared width depends on the short/full address select and on the configured character length. Software can also request mute at any time. In idle-line mode, that request is refused once an idle frame has already gone by.

Delivered characters appear one cycle after their input strobe. The mute flag is a register and changes on the clock edge after the event that causes it.

Top module: `uart_mute_filter`

## Requirements
- R1: After reset, `muted` is 0 and `rx_vld` is 0, and no idle frame counts as having elapsed, so a later mute request is honoured in idle-line mode.
- R2: When the character is not dropped, `rx_vld` pulses in the cycle after `char_vld`, and `rx_data` equals the input character unchanged. When not muted, every character is delivered, except an address character that does not match in address-mark mode (`wake_sel`=1).
- R3: In address-mark mode, a character is an address when its top data bit is 1. That bit is bit 6 for `data_len`=0 (7 bits), bit 7 for `data_len`=1 (8 bits, and also the reserved value 3), and bit 8 for `data_len`=2 (9 bits). All other characters are data.
- R4: With `addr7_sel`=0, bits [3:0] of the character are compared with `node_addr[3:0]`. With `addr7_sel`=1, the compare uses bits [5:0] for 7-bit characters, bits [6:0] for 8-bit characters, and bits [7:0] for 9-bit characters.
- R5: A non-matching address character sets `muted` in the next cycle and produces no `rx_vld`.
- R6: A matching address character clears `muted` and is itself delivered. The characters after it are delivered normally.
- R7: A `mute_req` pulse sets `muted` in the next cycle. The only exception is the case in R8.
- R8: In idle-line mode, `mute_req` is ignored if an `idle_pulse` has arrived since the last character, including one in the same cycle.
- R9: In idle-line mode, `idle_pulse` clears `muted`, and the next character is delivered. In address-mark mode, `idle_pulse` has no effect on `muted`.
- R10: While muted, every character other than a matching address is dropped. Data characters never change `muted`.
- R11: When `char_vld` and `mute_req` occur in the same cycle, the character is judged on the mute state before the request. The request then takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| char_vld | input | 1 | Character strobe from the deserializer |
| char_data | input | 9 | Received character, right-aligned |
| data_len | input | 2 | Character length: 0=7, 1=8, 2=9 bits, 3 treated as 8 |
| idle_pulse | input | 1 | One-cycle pulse when a full idle frame is detected |
| wake_sel | input | 1 | 0 = idle-line wake, 1 = address-mark wake |
| addr7_sel | input | 1 | 0 = 4-bit address compare, 1 = full-width compare |
| node_addr | input | 8 | This receiver's address |
| mute_req | input | 1 | Software mute request pulse |
| rx_vld | output | 1 | Delivered character strobe |
| rx_data | output | 9 | Delivered character |
| muted | output | 1 | Mute status |

## Verification
The bench checks the position of the address-mark bit for each character length. For example, with 7-bit characters a byte with bit 7 set but bit 6 clear is data. A filter that always looked at bit 7 would wrongly mute on it or wake on it. The bench also checks that the full-width compare covers 6, 7 or 8 bits. A wrong width would let a 9-bit address whose bit 7 differs match anyway.

In idle-line mode, the bench issues mute requests after an idle frame and after an intervening character. A design that lost track of the elapsed idle frame would either mute when it should not or refuse to mute when it should. Same-cycle collisions of a character with a mute request, and of an idle pulse with a character, check the ordering rule of R11. Long random traffic, compared every cycle against a reference model, covers mode switches in mid-stream.

// File: rtl/uart_mute_pkg.sv
package uart_mute_pkg;

   typedef enum logic {
      WAKE_IDLE = 1'b0,
      WAKE_ADDR = 1'b1
   } wake_e;

   typedef enum logic [1:0] {
      LEN_7   = 2'd0,
      LEN_8   = 2'd1,
      LEN_9   = 2'd2,
      LEN_RSV = 2'd3
   } dlen_e;

   // number of address bits taken for a full-width compare
   function automatic int unsigned full_cmp_width(dlen_e len, int unsigned node_w);
      case (len)
         LEN_7:   return node_w - 2;
         LEN_9:   return node_w;
         default: return node_w - 1;
      endcase
   endfunction

endpackage

// File: rtl/umf_classify.sv
module umf_classify
   import uart_mute_pkg::*;
#(
   parameter int CHAR_W  = 9,
   parameter int NODE_W  = 8,
   parameter int SHORT_W = 4
) (
   input  logic [CHAR_W-1:0] char_data,
   input  logic [1:0]        data_len,
   input  logic              addr7_sel,
   input  logic [NODE_W-1:0] node_addr,
   output logic              is_addr_mark,
   output logic              addr_hit
);

   localparam int CW_BITS = $clog2(NODE_W + 1);

   dlen_e              len;
   logic [CW_BITS-1:0] cmp_w;
   logic [NODE_W-1:0]  cmp_mask;
   logic [NODE_W-1:0]  bit_eq;

   assign len = dlen_e'(data_len);

   // mark bit sits at the top of the configured character length
   always_comb begin
      case (len)
         LEN_7:   is_addr_mark = char_data[CHAR_W-3];
         LEN_9:   is_addr_mark = char_data[CHAR_W-1];
         default: is_addr_mark = char_data[CHAR_W-2];
      endcase
   end

   always_comb begin
      if (addr7_sel) cmp_w = CW_BITS'(full_cmp_width(len, NODE_W));
      else           cmp_w = CW_BITS'(SHORT_W);
   end

   for (genvar i = 0; i < NODE_W; i++) begin : g_bit
      assign cmp_mask[i] = (CW_BITS'(i) < cmp_w);
      assign bit_eq[i]   = ~(char_data[i] ^ node_addr[i]);
   end

   assign addr_hit = &(bit_eq | ~cmp_mask);

endmodule

// File: rtl/umf_idle_track.sv
module umf_idle_track (
   input  logic clk,
   input  logic rst_n,
   input  logic char_vld,
   input  logic idle_pulse,
   output logic idle_seen
);

   // remembers that an idle frame went by with no character since
   always_ff @(posedge clk) begin
      if (!rst_n)          idle_seen <= 1'b0;
      else if (idle_pulse) idle_seen <= 1'b1;
      else if (char_vld)   idle_seen <= 1'b0;
   end

   a_r8_seen_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
      idle_pulse |=> idle_seen);

   a_r8_cleared_by_char: assert property (@(posedge clk) disable iff (!rst_n)
      (char_vld && !idle_pulse) |=> !idle_seen);

endmodule

// File: rtl/umf_mute_ctrl.sv
module umf_mute_ctrl
   import uart_mute_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic char_vld,
   input  logic wake_sel,
   input  logic is_addr_mark,
   input  logic addr_hit,
   input  logic idle_pulse,
   input  logic idle_seen,
   input  logic mute_req,
   output logic muted,
   output logic deliver
);

   wake_e wake;
   logic  addr_char;
   logic  req_block;
   logic  mute_nx;

   assign wake      = wake_e'(wake_sel);
   assign addr_char = (wake == WAKE_ADDR) && is_addr_mark;
   assign req_block = (wake == WAKE_IDLE) && (idle_seen || idle_pulse);

   // character judged first, then idle wake, then the software request
   always_comb begin
      deliver = 1'b0;
      mute_nx = muted;
      if (char_vld) begin
         if (addr_char) begin
            deliver = addr_hit;
            mute_nx = !addr_hit;
         end else begin
            deliver = !muted;
         end
      end
      if ((wake == WAKE_IDLE) && idle_pulse) mute_nx = 1'b0;
      if (mute_req && !req_block)            mute_nx = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) muted <= 1'b0;
      else        muted <= mute_nx;
   end

   a_r5_miss_mutes: assert property (@(posedge clk) disable iff (!rst_n)
      (char_vld && addr_char && !addr_hit) |=> muted);

   a_r6_hit_wakes: assert property (@(posedge clk) disable iff (!rst_n)
      (char_vld && addr_char && addr_hit && !mute_req) |=> !muted);

   a_r7_req_mutes: assert property (@(posedge clk) disable iff (!rst_n)
      (mute_req && wake == WAKE_ADDR) |=> muted);

   a_r8_req_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (mute_req && wake == WAKE_IDLE && idle_seen && !muted) |=> !muted);

   a_r9_idle_wakes: assert property (@(posedge clk) disable iff (!rst_n)
      (wake == WAKE_IDLE && idle_pulse && !mute_req) |=> !muted);

   a_r10_data_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (char_vld && !addr_char && !mute_req && !idle_pulse) |=> $stable(muted));

endmodule

// File: rtl/uart_mute_filter.sv
module uart_mute_filter
   import uart_mute_pkg::*;
#(
   parameter int CHAR_W  = 9,
   parameter int NODE_W  = 8,
   parameter int SHORT_W = 4,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              char_vld,
   input  logic [CHAR_W-1:0] char_data,
   input  logic [1:0]        data_len,
   input  logic              idle_pulse,
   input  logic              wake_sel,
   input  logic              addr7_sel,
   input  logic [NODE_W-1:0] node_addr,
   input  logic              mute_req,
   output logic              rx_vld,
   output logic [CHAR_W-1:0] rx_data,
   output logic              muted
);

   if (CHAR_W != 9)            $error("CHAR_W must be 9 for 7/8/9-bit characters");
   if (NODE_W != CHAR_W - 1)   $error("NODE_W must be CHAR_W-1");
   if (SHORT_W < 1 || SHORT_W > NODE_W - 2) $error("SHORT_W out of range");

   logic is_addr_mark;
   logic addr_hit;
   logic idle_seen;
   logic deliver;

   umf_classify #(
      .CHAR_W (CHAR_W),
      .NODE_W (NODE_W),
      .SHORT_W(SHORT_W)
   ) u_classify (
      .char_data   (char_data),
      .data_len    (data_len),
      .addr7_sel   (addr7_sel),
      .node_addr   (node_addr),
      .is_addr_mark(is_addr_mark),
      .addr_hit    (addr_hit)
   );

   umf_idle_track u_idle (
      .clk       (clk),
      .rst_n     (rst_n),
      .char_vld  (char_vld),
      .idle_pulse(idle_pulse),
      .idle_seen (idle_seen)
   );

   umf_mute_ctrl u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .char_vld    (char_vld),
      .wake_sel    (wake_sel),
      .is_addr_mark(is_addr_mark),
      .addr_hit    (addr_hit),
      .idle_pulse  (idle_pulse),
      .idle_seen   (idle_seen),
      .mute_req    (mute_req),
      .muted       (muted),
      .deliver     (deliver)
   );

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rx_vld  <= 1'b0;
            rx_data <= '0;
         end else begin
            rx_vld  <= char_vld && deliver;
            if (char_vld && deliver) rx_data <= char_data;
         end
      end

      a_r2_passes_char: assert property (@(posedge clk) disable iff (!rst_n)
         (char_vld && deliver) |=> (rx_vld && rx_data == $past(char_data)));

      a_r10_drops_char: assert property (@(posedge clk) disable iff (!rst_n)
         (char_vld && !deliver) |=> !rx_vld);
   end else begin : g_out_comb
      assign rx_vld  = char_vld && deliver;
      assign rx_data = char_data;
   end

endmodule

// File: tb/uart_mute_filter_bench.sv
module uart_mute_filter_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       char_vld = 1'b0;
   logic [8:0] char_data = '0;
   logic [1:0] data_len = 2'd1;
   logic       idle_pulse = 1'b0;
   logic       wake_sel = 1'b0;
   logic       addr7_sel = 1'b1;
   logic [7:0] node_addr = 8'h35;
   logic       mute_req = 1'b0;
   logic       rx_vld;
   logic [8:0] rx_data;
   logic       muted;

   int    total = 0;
   int    bad = 0;
   bit    done = 1'b0;
   string tag = "R1";

   // reference model state
   bit       m_muted = 1'b0;
   bit       m_seen = 1'b0;
   bit       m_vld = 1'b0;
   bit [8:0] m_data = '0;

   always #2 clk = ~clk;

   uart_mute_filter u_uart_mute_filter (
      .clk(clk), .rst_n(rst_n), .char_vld(char_vld), .char_data(char_data),
      .data_len(data_len), .idle_pulse(idle_pulse), .wake_sel(wake_sel),
      .addr7_sel(addr7_sel), .node_addr(node_addr), .mute_req(mute_req),
      .rx_vld(rx_vld), .rx_data(rx_data), .muted(muted)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference, updated at each edge, compared 1 ns later
   always @(posedge clk) begin
      if (!rst_n) begin
         m_muted = 0; m_seen = 0; m_vld = 0; m_data = '0;
      end else begin
         int  mark_bit;
         int  width;
         bit  is_adr;
         bit  hit;
         bit  nxt;
         int  mask;
         mark_bit = (data_len == 2'd0) ? 6 : (data_len == 2'd2) ? 8 : 7;
         width = !addr7_sel ? 4 : (data_len == 2'd0) ? 6 : (data_len == 2'd2) ? 8 : 7;
         mask = (1 << width) - 1;
         is_adr = wake_sel && char_data[mark_bit];
         hit = ((int'(char_data) & mask) == (int'(node_addr) & mask));
         nxt = m_muted;
         m_vld = 0;
         if (char_vld) begin
            if (is_adr) begin
               if (hit) begin nxt = 0; m_vld = 1; end
               else nxt = 1;
            end else if (!m_muted) m_vld = 1;
            if (m_vld) m_data = char_data;
         end
         if (!wake_sel && idle_pulse) nxt = 0;
         if (mute_req && !(!wake_sel && (m_seen || idle_pulse))) nxt = 1;
         m_muted = nxt;
         if (idle_pulse) m_seen = 1;
         else if (char_vld) m_seen = 0;
      end
      #1;
      if (!done) begin
         chk(muted == m_muted, tag, muted, m_muted);
         chk(rx_vld == m_vld, tag, rx_vld, m_vld);
         if (m_vld) chk(rx_data == m_data, tag, rx_data, m_data);
      end
   end

   // one cycle of stimulus, driven on the falling edge, then released
   task automatic cyc(input bit cv, input logic [8:0] d, input bit idl, input bit req);
      @(negedge clk);
      char_vld = cv; char_data = d; idle_pulse = idl; mute_req = req;
      @(negedge clk);
      char_vld = 0; idle_pulse = 0; mute_req = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(muted == 1'b0, "R1", muted, 0);
      chk(rx_vld == 1'b0, "R1", rx_vld, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(muted == 1'b0, "R1", muted, 0);

      // idle-line mode, 8-bit characters
      wake_sel = 0; data_len = 2'd1;
      tag = "R2";
      cyc(1, 9'h055, 0, 0);
      chk(rx_vld && rx_data == 9'h055, "R2", rx_data, 9'h055);
      tag = "R7";
      cyc(0, 0, 0, 1);
      chk(muted == 1'b1, "R7", muted, 1);
      tag = "R10";
      cyc(1, 9'h011, 0, 0);
      chk(rx_vld == 1'b0, "R10", rx_vld, 0);
      tag = "R9";
      cyc(0, 0, 1, 0);
      chk(muted == 1'b0, "R9", muted, 0);
      cyc(1, 9'h022, 0, 0);
      chk(rx_vld && rx_data == 9'h022, "R9", rx_data, 9'h022);
      tag = "R8";
      cyc(0, 0, 1, 0);
      cyc(0, 0, 0, 1);
      chk(muted == 1'b0, "R8", muted, 0);
      cyc(1, 9'h033, 0, 0);
      cyc(0, 0, 0, 1);
      chk(muted == 1'b1, "R8", muted, 1);
      cyc(0, 0, 1, 0);

      // address-mark mode, full compare, 8-bit characters, node 0x35
      wake_sel = 1; addr7_sel = 1; node_addr = 8'h35;
      tag = "R5";
      cyc(1, 9'h092, 0, 0);
      chk(rx_vld == 1'b0 && muted == 1'b1, "R5", {rx_vld, muted}, 2'b01);
      tag = "R10";
      cyc(1, 9'h044, 0, 0);
      chk(rx_vld == 1'b0 && muted == 1'b1, "R10", {rx_vld, muted}, 2'b01);
      tag = "R9";
      cyc(0, 0, 1, 0);
      chk(muted == 1'b1, "R9", muted, 1);
      tag = "R6";
      cyc(1, 9'h0B5, 0, 0);
      chk(rx_vld && rx_data == 9'h0B5 && !muted, "R6", rx_data, 9'h0B5);
      cyc(1, 9'h044, 0, 0);
      chk(rx_vld && rx_data == 9'h044, "R6", rx_data, 9'h044);

      // 7-bit characters: bit 6 marks, six bits compared
      tag = "R3";
      data_len = 2'd0;
      cyc(0, 0, 0, 1);
      cyc(1, 9'h080, 0, 0);
      chk(rx_vld == 1'b0 && muted == 1'b1, "R3", {rx_vld, muted}, 2'b01);
      cyc(1, 9'h075, 0, 0);
      chk(rx_vld && !muted, "R3", {rx_vld, muted}, 2'b10);

      // 9-bit characters: bit 8 marks, eight bits compared
      tag = "R4";
      data_len = 2'd2;
      cyc(1, 9'h1B5, 0, 0);
      chk(rx_vld == 1'b0 && muted == 1'b1, "R4", {rx_vld, muted}, 2'b01);
      cyc(1, 9'h135, 0, 0);
      chk(rx_vld && !muted, "R4", {rx_vld, muted}, 2'b10);

      // 4-bit compare
      data_len = 2'd1; addr7_sel = 0;
      cyc(1, 9'h0F6, 0, 0);
      chk(muted == 1'b1, "R4", muted, 1);
      cyc(1, 9'h085, 0, 0);
      chk(rx_vld && !muted, "R4", {rx_vld, muted}, 2'b10);

      // character and request together
      tag = "R11";
      cyc(1, 9'h010, 0, 1);
      chk(rx_vld && muted, "R11", {rx_vld, muted}, 2'b11);

      // random traffic against the model
      tag = "R2";
      for (int n = 0; n < 6000; n++) begin
         @(negedge clk);
         if ($urandom_range(0, 199) == 0) begin
            wake_sel = 1'($urandom);
            addr7_sel = 1'($urandom);
            data_len = 2'($urandom);
            node_addr = 8'($urandom);
         end
         char_vld = ($urandom_range(0, 9) < 4);
         char_data = 9'($urandom);
         if ($urandom_range(0, 3) == 0) char_data[3:0] = node_addr[3:0];
         idle_pulse = ($urandom_range(0, 11) == 0);
         mute_req = ($urandom_range(0, 9) == 0);
      end
      @(negedge clk);
      char_vld = 0; idle_pulse = 0; mute_req = 0;
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule